// File: doc/BRIEF.md
# Sequential Non-Restoring Divider

This unit divides an unsigned dividend by an unsigned divisor over several clock cycles. It takes one add-or-subtract step per clock on a signed partial remainder, and it gives back the quotient and a remainder that is never negative. With the default widths the dividend and the divisor are both 16 bits, and each division takes 17 steps plus one correction cycle.

The quotient is not built by shifting in one bit per step. Each step adds or subtracts a power-of-two weight, chosen by the sign of the partial remainder. The partial remainder moves by the divisor scaled by the same weight. One final cycle repairs a negative partial remainder: it adds the divisor back and lowers the quotient by one.

A caller pulses `start` while `busy` is low, then waits for the one-cycle `done` pulse. The results stay on the outputs until the next division completes. A zero divisor gives a result of no defined value.

Top module: `nrdiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high on a clock edge while `busy` is low captures `dividend` and `divisor`, and `busy` is high from that edge on.
- R3: `done` is high for exactly one cycle. It rises STEPS+1 clock edges after the accepting edge, where STEPS = DVD_W+1, which is 18 edges with the defaults. `busy` falls on the same edge that `done` rises.
- R4: A `start` pulse, or a change on `dividend` or `divisor`, while `busy` is high has no effect on the running division's result or on its timing.
- R5: For a nonzero divisor, `quotient` at `done` equals floor(dividend / divisor). For example, 32761 / 5 gives 6552 and 32227 / 37 gives 871.
- R6: For a nonzero divisor, `remainder` at `done` equals dividend mod divisor and is smaller than the divisor. For example, 32761 / 5 leaves 1 and 32227 / 37 leaves 0.
- R7: `quotient` and `remainder` keep their values from one completed division until the next division completes, whatever the inputs do in between.
- R8: A `start` in the same cycle that `done` is high is accepted. The next result then follows STEPS+1 edges later, with no idle cycle between the two divisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; taken only while busy is low |
| dividend | input | DVD_W | Unsigned dividend |
| divisor | input | DVS_W | Unsigned divisor, nonzero for a defined result |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results have just been updated |
| quotient | output | DVD_W | Unsigned quotient of the last completed division |
| remainder | output | DVS_W | Non-negative remainder of the last completed division |

## Verification
The correction cycle that completes one division can share a cycle with the acceptance of the next one. In that cycle `done` is high, `busy` is low and a new `start` arrives. The bench provokes this by raising `start` in exactly the cycle `done` is seen. It then checks that the first result is intact on the outputs, that the second division ends a full STEPS+1 edges later, and that the second result is correct. A `start` pulsed in the middle of a running division is also checked: neither the result nor the latency of that division may change.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int STEPS = 17,
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             step_fire,
  output logic             fix_fire,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);
  nrdiv_state_e     state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             last_step;

  assign accept    = start && (state_q == ST_IDLE);
  assign step_fire = (state_q == ST_RUN);
  assign fix_fire  = (state_q == ST_FIX);
  assign last_step = step_fire && (idx_q == '0);
  assign idx       = idx_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fix_fire;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          idx_q   <= IDX_W'(STEPS - 1);
        end
        ST_RUN: begin
          if (last_step) state_q <= ST_FIX;
          else           idx_q   <= idx_q - 1'b1;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: a running sequence only counts down, start cannot restart it
  assert_ignore_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !last_step) |=> (step_fire && idx_q == $past(idx_q) - 1'b1));
  // R3: done lasts one cycle and never overlaps busy
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3: correction follows the last step directly
  assert_fix_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> fix_fire);
endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int PR_W  = 33,
  parameter int QW    = 17,
  parameter int DVS_W = 16,
  parameter int IDX_W = 5
) (
  input  logic [PR_W-1:0]  rem_in,
  input  logic [QW-1:0]    quo_in,
  input  logic [DVS_W-1:0] dvs,
  input  logic [IDX_W-1:0] idx,
  output logic             rem_neg,
  output logic [PR_W-1:0]  rem_out,
  output logic [QW-1:0]    quo_out
);
  function automatic logic [PR_W-1:0] scaled_dvs(input logic [DVS_W-1:0] d,
                                                 input logic [IDX_W-1:0] k);
    return {{(PR_W-DVS_W){1'b0}}, d} << k;
  endfunction

  function automatic logic [QW-1:0] weight(input logic [IDX_W-1:0] k);
    return {{(QW-1){1'b0}}, 1'b1} << k;
  endfunction

  logic [PR_W-1:0] shifted;
  logic [QW-1:0]   wgt;

  assign rem_neg = rem_in[PR_W-1];
  assign shifted = scaled_dvs(dvs, idx);
  assign wgt     = weight(idx);

  always_comb begin
    if (rem_neg) begin
      rem_out = rem_in + shifted;
      quo_out = quo_in - wgt;
    end else begin
      rem_out = rem_in - shifted;
      quo_out = quo_in + wgt;
    end
  end
endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
  parameter int PR_W  = 33,
  parameter int QW    = 17,
  parameter int DVS_W = 16
) (
  input  logic [PR_W-1:0]  rem_in,
  input  logic [QW-1:0]    quo_in,
  input  logic [DVS_W-1:0] dvs,
  output logic             need_fix,
  output logic [PR_W-1:0]  rem_out,
  output logic [QW-1:0]    quo_out
);
  function automatic logic [PR_W-1:0] add_back(input logic [PR_W-1:0] r,
                                               input logic [DVS_W-1:0] d);
    return r + {{(PR_W-DVS_W){1'b0}}, d};
  endfunction

  assign need_fix = rem_in[PR_W-1];
  assign rem_out  = need_fix ? add_back(rem_in, dvs) : rem_in;
  assign quo_out  = need_fix ? quo_in - 1'b1 : quo_in;
endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit #(
  parameter int DVD_W = 16,
  parameter int DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient,
  output logic [DVS_W-1:0] remainder
);
  localparam int STEPS = DVD_W + 1;
  localparam int QW    = STEPS;
  localparam int PR_W  = DVS_W + STEPS;
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int CHK_W = DVD_W + DVS_W + 1;

  logic             accept, step_fire, fix_fire, rem_neg, need_fix;
  logic [IDX_W-1:0] idx;
  logic [PR_W-1:0]  rem_q, rem_nx, rem_fix;
  logic [QW-1:0]    quo_q, quo_nx, quo_fix;
  logic [DVS_W-1:0] dvs_q;
  logic [DVD_W-1:0] dvd_q;

  nrdiv_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .step_fire(step_fire), .fix_fire(fix_fire), .idx(idx),
    .busy(busy), .done(done)
  );

  nrdiv_step #(.PR_W(PR_W), .QW(QW), .DVS_W(DVS_W), .IDX_W(IDX_W)) u_step (
    .rem_in(rem_q), .quo_in(quo_q), .dvs(dvs_q), .idx(idx),
    .rem_neg(rem_neg), .rem_out(rem_nx), .quo_out(quo_nx)
  );

  nrdiv_fix #(.PR_W(PR_W), .QW(QW), .DVS_W(DVS_W)) u_fix (
    .rem_in(rem_q), .quo_in(quo_q), .dvs(dvs_q),
    .need_fix(need_fix), .rem_out(rem_fix), .quo_out(quo_fix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      dvd_q     <= '0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      if (accept) begin
        rem_q <= {{(PR_W-DVD_W){1'b0}}, dividend};
        quo_q <= '0;
        dvs_q <= divisor;
        dvd_q <= dividend;
      end else if (step_fire) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
      end
      if (fix_fire) begin
        quotient  <= quo_fix[DVD_W-1:0];
        remainder <= rem_fix[DVS_W-1:0];
      end
    end
  end

  logic [CHK_W-1:0] recombined;
  assign recombined = CHK_W'(quotient) * CHK_W'(dvs_q) + CHK_W'(remainder);

  // R6: corrected remainder is non-negative, fits the output and is below the divisor
  assert_rem_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_fire && dvs_q != '0) |->
      (rem_fix[PR_W-1:DVS_W] == '0 && rem_fix[DVS_W-1:0] < dvs_q));
  // R6: a negative partial remainder is never left uncorrected (no sign flip when adding back)
  assert_fix_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_fire && need_fix) |-> !rem_fix[PR_W-1]);
  // R5: quotient fits its output width before it is truncated
  assert_quo_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fix_fire |-> (quo_fix[QW-1] == 1'b0));
  // R5: quotient * divisor + remainder rebuilds the dividend
  assert_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_q != '0) |-> (recombined == CHK_W'(dvd_q)));
  // R7: results move only on a correction cycle
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_fire |=> ($stable(quotient) && $stable(remainder)));
  // R2: an accepted start makes the unit busy on the next cycle
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !rem_neg));
endmodule

// File: tb/nrdiv_unit_tb.sv
`timescale 1ns/1ps
module nrdiv_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // default configuration: 16 / 16 bits, 17 steps, latency 18
  logic        b_start = 1'b0;
  logic [15:0] b_dvd = '0, b_dvs = '0;
  logic        b_busy, b_done;
  logic [15:0] b_quo, b_rem;

  nrdiv_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(b_start), .dividend(b_dvd), .divisor(b_dvs),
    .busy(b_busy), .done(b_done), .quotient(b_quo), .remainder(b_rem)
  );

  // small configuration for the exhaustive sweep: 6 / 4 bits, latency 8
  logic       s_start = 1'b0;
  logic [5:0] s_dvd = '0;
  logic [3:0] s_dvs = '0;
  logic       s_busy, s_done;
  logic [5:0] s_quo;
  logic [3:0] s_rem;

  nrdiv_unit #(.DVD_W(6), .DVS_W(4)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .start(s_start), .dividend(s_dvd), .divisor(s_dvs),
    .busy(s_busy), .done(s_done), .quotient(s_quo), .remainder(s_rem)
  );

  localparam int BIG_LAT   = 18;
  localparam int SMALL_LAT = 8;

  // wait for done on the big instance, counting edges after the accepting one
  task automatic big_wait(input bit poke, output int lat);
    lat = 0;
    while (!b_done && lat < 100) begin
      if (poke && lat == 5) begin
        b_start = 1'b1;
        b_dvd   = 16'hFFFF;
        b_dvs   = 16'd3;
      end else begin
        b_start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    b_start = 1'b0;
  endtask

  task automatic big_run(input int a, input int d, input bit poke, input bit full);
    int lat;
    @(negedge clk);
    b_start = 1'b1; b_dvd = 16'(a); b_dvs = 16'(d);
    @(negedge clk);
    b_start = 1'b0;
    if (full) chk(b_busy == 1'b1, "R2 busy after start", b_busy, 1);
    big_wait(poke, lat);
    chk(b_quo == 16'(a / d), poke ? "R4 R5 quotient" : "R5 quotient", b_quo, a / d);
    chk(b_rem == 16'(a % d), poke ? "R4 R6 remainder" : "R6 remainder", b_rem, a % d);
    if (full) begin
      chk(lat == BIG_LAT, poke ? "R4 R3 latency" : "R3 latency", lat, BIG_LAT);
      chk(b_busy == 1'b0, "R3 busy low with done", b_busy, 0);
      @(negedge clk);
      chk(b_done == 1'b0, "R3 done one cycle", b_done, 0);
    end
  endtask

  task automatic small_run(input int a, input int d);
    int lat;
    @(negedge clk);
    s_start = 1'b1; s_dvd = 6'(a); s_dvs = 4'(d);
    @(negedge clk);
    s_start = 1'b0;
    lat = 0;
    while (!s_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(s_quo == 6'(a / d), "R5 sweep quotient", s_quo, a / d);
    chk(s_rem == 4'(a % d), "R6 sweep remainder", s_rem, a % d);
    chk(lat == SMALL_LAT, "R3 sweep latency", lat, SMALL_LAT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(b_busy == 0, "R1 busy reset", b_busy, 0);
    chk(b_done == 0, "R1 done reset", b_done, 0);
    chk(b_quo == 0, "R1 quotient reset", b_quo, 0);
    chk(b_rem == 0, "R1 remainder reset", b_rem, 0);

    big_run(32761, 5, 0, 1);
    big_run(32227, 37, 0, 1);
    big_run(0, 1, 0, 1);
    big_run(65535, 1, 0, 1);
    big_run(65535, 65535, 0, 1);
    big_run(1, 65535, 0, 1);
    big_run(65534, 65535, 0, 1);
    big_run(40000, 200, 0, 1);
    big_run(12345, 7, 1, 1);   // R4 start and operand change mid-division

    // R7 results hold while inputs wander
    for (int k = 0; k < 4; k++) begin
      b_dvd = 16'(k * 999); b_dvs = 16'(k + 2);
      @(negedge clk);
    end
    chk(b_quo == 16'(12345 / 7), "R7 quotient held", b_quo, 12345 / 7);
    chk(b_rem == 16'(12345 % 7), "R7 remainder held", b_rem, 12345 % 7);
    chk(b_done == 0, "R7 no spurious done", b_done, 0);

    // R8 back-to-back: start issued in the done cycle
    @(negedge clk);
    b_start = 1'b1; b_dvd = 16'd100; b_dvs = 16'd7;
    @(negedge clk);
    b_start = 1'b0;
    big_wait(0, lat);
    b_start = 1'b1; b_dvd = 16'd200; b_dvs = 16'd9;
    chk(b_quo == 16'd14, "R8 first quotient", b_quo, 14);
    chk(b_rem == 16'd2, "R8 first remainder", b_rem, 2);
    @(negedge clk);
    b_start = 1'b0;
    chk(b_busy == 1'b1, "R8 second accepted", b_busy, 1);
    big_wait(0, lat);
    chk(lat == BIG_LAT, "R8 second latency", lat, BIG_LAT);
    chk(b_quo == 16'd22, "R8 second quotient", b_quo, 22);
    chk(b_rem == 16'd2, "R8 second remainder", b_rem, 2);

    // near-sweep of the wide configuration
    for (int i = 0; i < 150; i++) begin
      int a, d;
      a = (i * 4373 + 17) % 65536;
      d = ((i * 911) % 65535) + 1;
      if (i % 3 == 0) d = (i % 40) + 1;
      big_run(a, d, 0, 0);
    end

    // exhaustive sweep of the small configuration
    for (int d = 1; d < 16; d++) begin
      for (int a = 0; a < 64; a++) begin
        small_run(a, d);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule